// File: doc/BRIEF.md
# Serial Port Register Front End with Prioritised Interrupt

This block is the byte-wide register side of a 16550-compatible serial port. A host reaches eight byte offsets over a simple strobe bus: an offset, write data, a write strobe, a read strobe and combinational read data. The block holds the interrupt enables, line control, FIFO mode, modem control, a scratch byte and the 16-bit baud divisor. It fronts a receive FIFO whose usable capacity is one byte in character mode and `RX_DEPTH` bytes in FIFO mode. It raises one level interrupt whose cause is reported through the interrupt identification read.

Received bytes arrive on a valid/ready stream. A byte moves on any cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` drops while loopback is on, while the FIFO is full at its current capacity, and during a cycle in which a FIFO-control write flushes the FIFO. The sender must hold its byte until `rx_ready` returns. Transmit bytes leave as a one-cycle `tx_valid` strobe with no ready, because the transmitter is taken to be always ready. When loopback is on, a data write goes into the receive FIFO and produces no transmit strobe.

Bit timing, baud generation and the line driver sit outside this block. It exports the divisor and the modem-control bits, and takes the modem status byte from a neighbouring block. When the host reads that byte, `modem_rd_strobe` pulses so the neighbour can clear its change bits. If both strobes are high together, the write is performed and the read is ignored. A read takes its side effects at the clock edge that ends it.

Top module: `uart_regfile`

## Requirements
- R1: After reset the divisor is 0x0001, interrupt enables, line control, modem control and FIFO mode are zero, `irq` is low, and the FIFO capacity is one byte.
- R2: While line-control bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. `divisor` outputs {high, low}.
- R3: Writes to offset 1 (with bit 7 of line control clear) keep only bits 3:0; bits 7:4 read as zero. Bit 0 enables receive, bit 1 enables transmit-empty, bit 2 enables line status, and bit 3 enables modem status.
- R4: A transmit-empty pending flag is set by every data write, and by an enable write that takes bit 1 from 0 to 1 (a write that leaves bit 1 at 1 does not set it). The flag is cleared by an offset-2 read that returns the transmit-empty code.
- R5: Offset-2 reads return the highest active cause in this order: overrun with enable bit 2 gives 0x06; a non-empty FIFO with enable bit 0 gives 0x0C; pending transmit-empty with enable bit 1 gives 0x02; any of modem status bits 3:0 with enable bit 3 gives 0x00. With no active cause the read returns 0x01. Bits 7:6 both read as 1 while FIFO mode is on.
- R6: Offset-5 reads return bit 6 = 1, bit 5 = 1, bit 1 = overrun and bit 0 = FIFO not empty. The overrun bit is cleared after the read.
- R7: With modem-control bit 4 (loopback) set, a data write pushes the byte into the receive FIFO. A write that finds the FIFO full is dropped and sets overrun.
- R8: An offset-2 write that changes bit 0 flushes the FIFO. The new capacity is `RX_DEPTH` when bit 0 becomes 1 and one byte when it becomes 0. A write with bit 0 clear leaves FIFO mode off. A write with bits 0 and 1 both set flushes the FIFO.
- R9: Offset-0 reads (bit 7 of line control clear) pop the FIFO in arrival order. On an empty FIFO they return 0x00 and change nothing.
- R10: Writes to offsets 5 and 6 have no effect. Offset-6 reads return `modem_status` and pulse `modem_rd_strobe` during the read.
- R11: `irq` is high exactly while the offset-2 cause would be other than 0x01. It follows register and input changes without waiting for an access.
- R12: `rx_ready` is low while loopback is on or the FIFO is full, and an accepted stream byte is queued.
- R13: A data write with loopback off gives `tx_valid` high for the next cycle with the written byte on `tx_data`. With loopback on there is no strobe.
- R14: Line control and scratch read back as written. Modem control keeps bits 4:0, reads back masked, and drives `modem_ctrl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe, side effects at the closing edge |
| host_rdata | output | 8 | Read data, valid while `host_rd` is high |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | FIFO accepts the offered byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Byte to transmit |
| modem_status | input | 8 | Modem status byte with change bits in 3:0 |
| modem_rd_strobe | output | 1 | High during a modem status read |
| modem_ctrl | output | 5 | Modem control bits, bit 4 is loopback |
| divisor | output | 16 | Baud divisor {high, low} |
| irq | output | 1 | Level interrupt request |

## Verification
The cause selection is exercised with single causes alone and with overlapping sets. The overlapping cases are overrun over queued data, queued data over a pending transmit-empty flag, and transmit-empty over a modem change. Each of these shows whether the ordering, and not just the presence of a cause, is right. The FIFO is filled in character mode and in FIFO mode, past one byte and past sixteen. This separates a capacity that follows the mode bit from a fixed one, and a flush on mode change or reset bit from a stale queue. Loopback on and off is alternated around data writes to show that the transmit strobe, the FIFO push and the stream ready each respond only in their own mode.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    OFF_DATA    = 3'd0,
    OFF_IEN     = 3'd1,
    OFF_IDENT   = 3'd2,
    OFF_LINE    = 3'd3,
    OFF_MCTL    = 3'd4,
    OFF_LSTAT   = 3'd5,
    OFF_MSTAT   = 3'd6,
    OFF_SCRATCH = 3'd7
  } reg_off_e;

  typedef enum logic [3:0] {
    WHY_MODEM = 4'h0,
    WHY_NONE  = 4'h1,
    WHY_TXE   = 4'h2,
    WHY_LINE  = 4'h6,
    WHY_RXTO  = 4'hC
  } irq_why_e;

  localparam int unsigned IEN_RX    = 0;
  localparam int unsigned IEN_TXE   = 1;
  localparam int unsigned IEN_LINE  = 2;
  localparam int unsigned IEN_MODEM = 3;

  localparam int unsigned LINE_DLAB = 7;
  localparam int unsigned MCTL_LOOP = 4;
  localparam int unsigned FMODE_EN  = 0;
  localparam int unsigned FMODE_RST = 1;

endpackage

// File: rtl/uart_rf_rx_fifo.sv
module uart_rf_rx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          flush_wide,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] level_q;
  logic             wide_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      wide_q   <= 1'b0;
    end else if (flush) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      wide_q   <= flush_wide;
    end else begin
      if (push) wr_ptr_q <= bump(wr_ptr_q);
      if (pop)  rd_ptr_q <= bump(rd_ptr_q);
      case ({push, pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem_q[wr_ptr_q] <= push_data;
  end

  assign head  = mem_q[rd_ptr_q];
  assign empty = (level_q == '0);
  assign full  = wide_q ? (level_q == FULL_CNT) : !empty;

  // R7: the front end never pushes into a full queue
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> !full);
  // R9: a pop only happens on a non-empty queue
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush) |-> !empty);
  // R8: the fill level stays within the storage
  assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= FULL_CNT);
  // R8: in character mode at most one byte is held
  assert_narrow_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_q |-> (level_q <= 1));

endmodule

// File: rtl/uart_rf_irq_sel.sv
module uart_rf_irq_sel
  import uart_rf_pkg::*;
(
  input  logic [3:0] ien,
  input  logic       overrun,
  input  logic       rx_nonempty,
  input  logic       txe_pending,
  input  logic       modem_delta,
  output irq_why_e   why,
  output logic       irq
);
  always_comb begin
    if (overrun && ien[IEN_LINE])            why = WHY_LINE;
    else if (rx_nonempty && ien[IEN_RX])     why = WHY_RXTO;
    else if (txe_pending && ien[IEN_TXE])    why = WHY_TXE;
    else if (modem_delta && ien[IEN_MODEM])  why = WHY_MODEM;
    else                                     why = WHY_NONE;
  end

  assign irq = (why != WHY_NONE);

  // R5: an enabled overrun always outranks the other causes
  always_comb begin
    if (overrun && ien[IEN_LINE])
      assert_line_first_R5: assert (irq) else $error("line cause lost");
  end

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  host_addr,
  input  logic [7:0]  host_wdata,
  input  logic        host_wr,
  input  logic        host_rd,
  output logic [7:0]  host_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic [7:0]  modem_status,
  output logic        modem_rd_strobe,
  output logic [4:0]  modem_ctrl,
  output logic [15:0] divisor,
  output logic        irq
);
  localparam logic [7:0] DIV_RESET_LO = 8'd1;   // 1843200 / 115200 / 16
  localparam logic [7:0] DIV_RESET_HI = 8'd0;

  // register state
  logic [3:0] ien_q;
  logic [7:0] line_q;
  logic [4:0] mctl_q;
  logic [7:0] scratch_q;
  logic [7:0] div_lo_q, div_hi_q;
  logic       fmode_q;
  logic       overrun_q;
  logic       txe_pend_q;
  logic       tx_valid_q;
  logic [7:0] tx_data_q;

  // decode
  reg_off_e off;
  logic     wr_acc, rd_acc, dlab, loop_on;
  logic     wr_div_lo, wr_div_hi, wr_thr, wr_ien, wr_fmode, wr_line, wr_mctl, wr_scr;
  logic     rd_rbr, rd_ident, rd_lstat, rd_mstat;

  assign off     = reg_off_e'(host_addr);
  assign wr_acc  = host_wr;
  assign rd_acc  = host_rd && !host_wr;
  assign dlab    = line_q[LINE_DLAB];
  assign loop_on = mctl_q[MCTL_LOOP];

  assign wr_div_lo = wr_acc &&  dlab && (off == OFF_DATA);
  assign wr_div_hi = wr_acc &&  dlab && (off == OFF_IEN);
  assign wr_thr    = wr_acc && !dlab && (off == OFF_DATA);
  assign wr_ien    = wr_acc && !dlab && (off == OFF_IEN);
  assign wr_fmode  = wr_acc && (off == OFF_IDENT);
  assign wr_line   = wr_acc && (off == OFF_LINE);
  assign wr_mctl   = wr_acc && (off == OFF_MCTL);
  assign wr_scr    = wr_acc && (off == OFF_SCRATCH);

  assign rd_rbr   = rd_acc && !dlab && (off == OFF_DATA);
  assign rd_ident = rd_acc && (off == OFF_IDENT);
  assign rd_lstat = rd_acc && (off == OFF_LSTAT);
  assign rd_mstat = rd_acc && (off == OFF_MSTAT);

  // receive queue control
  logic       fifo_flush, fifo_wide, fifo_push, fifo_pop;
  logic       rx_empty, rx_full, lb_push, lb_drop, rx_take;
  logic [7:0] fifo_head, fifo_in;

  assign fifo_flush = wr_fmode &&
                      ((fmode_q != host_wdata[FMODE_EN]) ||
                       (host_wdata[FMODE_EN] && host_wdata[FMODE_RST]));
  assign fifo_wide  = host_wdata[FMODE_EN];

  assign lb_push  = wr_thr && loop_on && !rx_full;
  assign lb_drop  = wr_thr && loop_on &&  rx_full;
  assign rx_ready = !loop_on && !rx_full && !fifo_flush;
  assign rx_take  = rx_valid && rx_ready;
  assign fifo_push = lb_push || rx_take;
  assign fifo_in   = lb_push ? host_wdata : rx_data;
  assign fifo_pop  = rd_rbr && !rx_empty;

  uart_rf_rx_fifo #(
    .DEPTH (RX_DEPTH),
    .DW    (BYTE_W)
  ) i_rx_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (fifo_flush),
    .flush_wide (fifo_wide),
    .push       (fifo_push),
    .push_data  (fifo_in),
    .pop        (fifo_pop),
    .head       (fifo_head),
    .empty      (rx_empty),
    .full       (rx_full)
  );

  // interrupt cause
  irq_why_e why;

  uart_rf_irq_sel i_irq_sel (
    .ien         (ien_q),
    .overrun     (overrun_q),
    .rx_nonempty (!rx_empty),
    .txe_pending (txe_pend_q),
    .modem_delta (|modem_status[3:0]),
    .why         (why),
    .irq         (irq)
  );

  // register updates
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q      <= '0;
      line_q     <= '0;
      mctl_q     <= '0;
      scratch_q  <= '0;
      div_lo_q   <= DIV_RESET_LO;
      div_hi_q   <= DIV_RESET_HI;
      fmode_q    <= 1'b0;
      overrun_q  <= 1'b0;
      txe_pend_q <= 1'b0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      tx_valid_q <= wr_thr && !loop_on;
      if (wr_thr && !loop_on) tx_data_q <= host_wdata;
      if (wr_div_lo) div_lo_q  <= host_wdata;
      if (wr_div_hi) div_hi_q  <= host_wdata;
      if (wr_ien)    ien_q     <= host_wdata[3:0];
      if (wr_line)   line_q    <= host_wdata;
      if (wr_mctl)   mctl_q    <= host_wdata[4:0];
      if (wr_scr)    scratch_q <= host_wdata;
      if (wr_fmode)  fmode_q   <= host_wdata[FMODE_EN];

      if (lb_drop)       overrun_q <= 1'b1;
      else if (rd_lstat) overrun_q <= 1'b0;

      if (wr_thr || (wr_ien && !ien_q[IEN_TXE] && host_wdata[IEN_TXE]))
        txe_pend_q <= 1'b1;
      else if (rd_ident && (why == WHY_TXE))
        txe_pend_q <= 1'b0;
    end
  end

  // read data
  always_comb begin
    host_rdata = '0;
    if (rd_acc) begin
      case (off)
        OFF_DATA:    host_rdata = dlab ? div_lo_q : (rx_empty ? 8'h00 : fifo_head);
        OFF_IEN:     host_rdata = dlab ? div_hi_q : {4'b0000, ien_q};
        OFF_IDENT:   host_rdata = {fmode_q, fmode_q, 2'b00, why};
        OFF_LINE:    host_rdata = line_q;
        OFF_MCTL:    host_rdata = {3'b000, mctl_q};
        OFF_LSTAT:   host_rdata = {1'b0, 1'b1, 1'b1, 3'b000, overrun_q, !rx_empty};
        OFF_MSTAT:   host_rdata = modem_status;
        OFF_SCRATCH: host_rdata = scratch_q;
        default:     host_rdata = 8'hFF;
      endcase
    end
  end

  assign tx_valid        = tx_valid_q;
  assign tx_data         = tx_data_q;
  assign modem_rd_strobe = rd_mstat;
  assign modem_ctrl      = mctl_q;
  assign divisor         = {div_hi_q, div_lo_q};

  // R6: a status read leaves overrun clear
  assert_ovr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lstat |=> !overrun_q);
  // R4: a data write leaves the transmit-empty flag pending
  assert_txe_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thr |=> txe_pend_q);
  // R4: an identification read that reported transmit-empty consumes it
  assert_txe_consume_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ident && host_rdata[3:0] == 4'h2) |=> !txe_pend_q);
  // R12: the stream is held off in loopback
  assert_stream_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !mctl_q[MCTL_LOOP]);
  // R13: a transmit strobe lasts one cycle per write
  assert_tx_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !$past(wr_thr)) |-> 1'b0);

endmodule

// File: tb/test_uart_regfile.sv
`timescale 1ns/1ps
module test_uart_regfile;
  localparam time CLK_PERIOD = 20ns;
  localparam int  NVEC = 35;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic [7:0]  modem_status = '0;
  logic        modem_rd_strobe;
  logic [4:0]  modem_ctrl;
  logic [15:0] divisor;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic last_strobe;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regfile i_uart_regfile (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data),
    .modem_status(modem_status), .modem_rd_strobe(modem_rd_strobe),
    .modem_ctrl(modem_ctrl), .divisor(divisor), .irq(irq)
  );

  // {write, offset, wdata, expected, requirement number}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b0, 3'd5, 8'h00, 8'h60, 4'd6},   // R6 status after reset
    {1'b0, 3'd1, 8'h00, 8'h00, 4'd1},   // R1 enables zero
    {1'b1, 3'd3, 8'h80, 8'h00, 4'd0},
    {1'b0, 3'd0, 8'h00, 8'h01, 4'd1},   // R1 divisor low
    {1'b0, 3'd1, 8'h00, 8'h00, 4'd1},   // R1 divisor high
    {1'b1, 3'd0, 8'h34, 8'h00, 4'd0},
    {1'b1, 3'd1, 8'h12, 8'h00, 4'd0},
    {1'b0, 3'd0, 8'h00, 8'h34, 4'd2},   // R2
    {1'b0, 3'd1, 8'h00, 8'h12, 4'd2},   // R2
    {1'b1, 3'd3, 8'h03, 8'h00, 4'd0},
    {1'b0, 3'd3, 8'h00, 8'h03, 4'd14},  // R14 line control
    {1'b0, 3'd0, 8'h00, 8'h00, 4'd9},   // R9 empty read
    {1'b1, 3'd1, 8'hFF, 8'h00, 4'd0},
    {1'b0, 3'd1, 8'h00, 8'h0F, 4'd3},   // R3 mask
    {1'b0, 3'd2, 8'h00, 8'h02, 4'd5},   // R5 transmit-empty
    {1'b0, 3'd2, 8'h00, 8'h01, 4'd4},   // R4 consumed
    {1'b1, 3'd1, 8'h0F, 8'h00, 4'd0},
    {1'b0, 3'd2, 8'h00, 8'h01, 4'd4},   // R4 no edge
    {1'b1, 3'd7, 8'hA5, 8'h00, 4'd0},
    {1'b0, 3'd7, 8'h00, 8'hA5, 4'd14},  // R14 scratch
    {1'b1, 3'd4, 8'hFF, 8'h00, 4'd0},
    {1'b0, 3'd4, 8'h00, 8'h1F, 4'd14},  // R14 modem control mask
    {1'b1, 3'd0, 8'h55, 8'h00, 4'd0},
    {1'b0, 3'd2, 8'h00, 8'h0C, 4'd5},   // R5 rx outranks tx
    {1'b0, 3'd5, 8'h00, 8'h61, 4'd6},   // R6 data ready
    {1'b1, 3'd0, 8'h66, 8'h00, 4'd0},
    {1'b0, 3'd2, 8'h00, 8'h06, 4'd5},   // R5 overrun first
    {1'b0, 3'd5, 8'h00, 8'h63, 4'd7},   // R7 overrun set
    {1'b0, 3'd5, 8'h00, 8'h61, 4'd6},   // R6 overrun cleared
    {1'b0, 3'd0, 8'h00, 8'h55, 4'd9},   // R9 pop
    {1'b0, 3'd0, 8'h00, 8'h00, 4'd9},   // R9 empty
    {1'b0, 3'd2, 8'h00, 8'h02, 4'd5},   // R5 tx pending remains
    {1'b0, 3'd2, 8'h00, 8'h01, 4'd4},   // R4
    {1'b1, 3'd5, 8'hFF, 8'h00, 4'd0},
    {1'b0, 3'd5, 8'h00, 8'h60, 4'd10}   // R10 status write ignored
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #5;
    last_strobe = modem_rd_strobe;
    check(tag, {8'h00, host_rdata}, {8'h00, e});
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    check("R1 irq at reset", {15'd0, irq}, 16'd0);
    check("R1 divisor at reset", divisor, 16'h0001);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][23]) do_wr(VEC[i][22:20], VEC[i][19:12]);
      else do_rd(VEC[i][22:20], VEC[i][11:4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
    end

    check("R2 divisor port", divisor, 16'h1234);
    check("R11 idle irq", {15'd0, irq}, 16'd0);

    // R8 FIFO mode: sixteen bytes fit
    do_wr(3'd2, 8'h01);
    for (int k = 0; k < 16; k++) do_wr(3'd0, 8'h10 + 8'(k));
    do_rd(3'd5, 8'h61, "R8 sixteen fit");
    do_rd(3'd2, 8'hCC, "R5 mode bits");
    do_wr(3'd0, 8'h77);
    do_rd(3'd5, 8'h63, "R7 seventeenth overruns");
    do_rd(3'd0, 8'h10, "R9 arrival order");
    do_wr(3'd2, 8'h03);
    do_rd(3'd5, 8'h60, "R8 reset bit flush");
    do_wr(3'd2, 8'h00);
    do_rd(3'd2, 8'h02, "R8 mode off");
    do_rd(3'd2, 8'h01, "R4 cleared");
    do_wr(3'd0, 8'hA1);
    do_wr(3'd0, 8'hA2);
    do_rd(3'd5, 8'h63, "R8 one-byte capacity");
    do_rd(3'd0, 8'hA1, "R9 first kept");
    do_rd(3'd5, 8'h60, "R9 now empty");
    do_rd(3'd2, 8'h02, "R4 pending");
    do_rd(3'd2, 8'h01, "R4 cleared");

    // R12 receive stream
    do_wr(3'd4, 8'h00);
    #5 check("R12 ready idle", {15'd0, rx_ready}, 16'd1);
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h9A;
    @(negedge clk); rx_valid = 1'b0;
    #5 check("R12 ready when full", {15'd0, rx_ready}, 16'd0);
    check("R11 irq rx", {15'd0, irq}, 16'd1);
    do_rd(3'd0, 8'h9A, "R12 byte queued");
    #5 check("R12 ready again", {15'd0, rx_ready}, 16'd1);
    do_wr(3'd4, 8'h10);
    #5 check("R12 loopback holds off", {15'd0, rx_ready}, 16'd0);

    // R13 transmit strobe
    do_wr(3'd4, 8'h00);
    do_wr(3'd0, 8'h3C);
    check("R13 tx strobe", {7'd0, tx_valid, tx_data}, {7'd0, 1'b1, 8'h3C});
    @(negedge clk);
    check("R13 strobe ends", {15'd0, tx_valid}, 16'd0);
    do_wr(3'd4, 8'h10);
    do_wr(3'd0, 8'h44);
    check("R13 none in loopback", {15'd0, tx_valid}, 16'd0);
    do_rd(3'd0, 8'h44, "R7 looped byte");
    do_wr(3'd4, 8'h00);
    do_rd(3'd2, 8'h02, "R4 pending");
    do_rd(3'd2, 8'h01, "R4 cleared");

    // R5 / R10 modem cause
    modem_status = 8'hB1;
    do_rd(3'd2, 8'h00, "R5 modem cause");
    check("R11 irq modem", {15'd0, irq}, 16'd1);
    do_wr(3'd6, 8'hFF);
    do_rd(3'd6, 8'hB1, "R10 modem read");
    check("R10 modem strobe", {15'd0, last_strobe}, 16'd1);
    modem_status = 8'h00;
    do_rd(3'd2, 8'h01, "R5 none");
    check("R11 irq low", {15'd0, irq}, 16'd0);

    // R4 enable edge
    do_wr(3'd1, 8'h00);
    do_rd(3'd2, 8'h01, "R4 disabled");
    do_wr(3'd1, 8'h02);
    do_rd(3'd2, 8'h02, "R4 edge sets");

    do_wr(3'd4, 8'hEB);
    check("R14 modem_ctrl", {11'd0, modem_ctrl}, 16'h000B);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #5;
    check("R1 irq reset", {15'd0, irq}, 16'd0);
    check("R1 divisor reset", divisor, 16'h0001);
    check("R1 modem_ctrl reset", {11'd0, modem_ctrl}, 16'd0);
    @(negedge clk); rst_n = 1'b1;
    do_rd(3'd3, 8'h00, "R1 line control");
    do_rd(3'd5, 8'h60, "R1 status");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule